// File: doc/BRIEF.md
# Instruction Issue Stage with Register Hazard Scoreboard

This block sits between an instruction decoder and an execution unit. It takes one decoded instruction per cycle from upstream and holds it in a single-entry output slot. Each instruction carries a tag, two source register numbers, a destination register with a write-enable bit, and an update flag. The update flag marks a memory operation that also writes its base register back. The slot's content is offered downstream. The downstream unit answers in the same cycle with `busy`, meaning "I did not take what you offered". The stage keeps offering the same instruction until it is taken. As soon as it is taken, the slot refills from upstream in that same edge.

A small scoreboard holds one pending bit for each register written by an instruction that has left the stage but has not completed. A completion port clears one bit per cycle. That register then stays blocked for one further cycle before it counts as safe. An instruction stays in the slot, and is not offered, while any register it reads or writes is pending or in that extra cycle. A flush empties the slot, refuses the upstream instruction in that cycle and wipes the scoreboard.

Top module: `issue_stage`

## Requirements
- R1: While `out_valid` is 1 and `busy` is 1, the same instruction (all `out_*` fields unchanged) is offered again in the next cycle, unless `flush` is asserted.
- R2: When an offered instruction is taken (`out_valid`=1, `busy`=0) and `in_valid` is 1 in that cycle, the upstream instruction is captured at that edge and occupies the slot in the very next cycle.
- R3: `stall` is 1 exactly when the slot is occupied and its instruction is not taken this cycle; with an empty slot `stall` is 0 and `in_valid` is captured.
- R4: An instruction whose `out_ra` or `out_rb` names a register with a pending write is held with `out_valid`=0.
- R5: A taken instruction with `in_ra_upd`=1 marks its `ra` register pending, which blocks later readers of that register.
- R6: A taken instruction with `rt_wr`=1 marks `rt` pending; a later instruction writing the same `rt` is held until that write completes.
- R7: A completion on `cmp_reg` in cycle t keeps that register blocked in cycle t+1; an instruction waiting only on it is offered in cycle t+2.
- R8: `flush` forces `out_valid` to 0 in its cycle, refuses the upstream instruction, empties the slot and clears every pending and draining mark.
- R9: While `rst` is 1 and after its release, the slot is empty, `out_valid` and `stall` are 0 and no register is pending.
- R10: Every instruction taken from upstream is accepted downstream exactly once, in the order it arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream instruction present |
| in_tag | input | TAG_W | Upstream instruction identifier |
| in_ra | input | RW | First source / base register |
| in_rb | input | RW | Second source register |
| in_rt | input | RW | Destination register |
| in_rt_wr | input | 1 | Destination is written |
| in_ra_upd | input | 1 | Base register `in_ra` is written back |
| stall | output | 1 | Upstream must hold its instruction |
| out_valid | output | 1 | Slot instruction is offered downstream |
| out_tag | output | TAG_W | Offered instruction identifier |
| out_ra | output | RW | Offered first source / base register |
| out_rb | output | RW | Offered second source register |
| out_rt | output | RW | Offered destination register |
| out_rt_wr | output | 1 | Offered destination write enable |
| out_ra_upd | output | 1 | Offered base-update flag |
| busy | input | 1 | Downstream did not take the offer this cycle |
| flush | input | 1 | Discard slot, input and scoreboard |
| cmp_valid | input | 1 | A register write has completed |
| cmp_reg | input | RW | Register whose write completed |

## Verification
Directed sequences cover several patterns. A run of busy cycles shows whether the offer is held or lost. A read-after-write pair and an update-form base write followed by a reader show whether each source of a pending mark blocks. A write-after-write pair checks the destination comparison. The cycle-exact timing around a completion separates the extra drain cycle from an immediate release. A flush against a blocked slot shows that both the held instruction and the scoreboard are discarded. Randomized passes over four registers sweep the busy density from none to heavy while completions arrive at random, and a bench model tracks pending and draining registers. These passes expose reordering, duplicate or lost acceptances, and any acceptance that slips past a hazard.

// File: rtl/issue_pkg.sv
package issue_pkg;

  typedef enum logic {
    SLOT_EMPTY = 1'b0,
    SLOT_FULL  = 1'b1
  } slot_e;

  // True when register number r is used (en) and equals index idx.
  function automatic logic reg_match(input int unsigned r, input logic en,
                                     input int unsigned idx);
    return en && (r == idx);
  endfunction

  // True when an instruction touching registers (ra, rb, rt) collides with
  // blocked register idx: both sources always, rt only when written.
  function automatic logic instr_touches(input int unsigned ra, input int unsigned rb,
                                         input int unsigned rt, input logic rt_wr,
                                         input int unsigned idx);
    return reg_match(ra, 1'b1, idx) || reg_match(rb, 1'b1, idx) ||
           reg_match(rt, rt_wr, idx);
  endfunction

endpackage

// File: rtl/issue_slot.sv
module issue_slot
  import issue_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int RW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             load,
  input  logic             unload,
  input  logic [TAG_W-1:0] d_tag,
  input  logic [RW-1:0]    d_ra,
  input  logic [RW-1:0]    d_rb,
  input  logic [RW-1:0]    d_rt,
  input  logic             d_rt_wr,
  input  logic             d_ra_upd,
  output logic             occ,
  output logic [TAG_W-1:0] q_tag,
  output logic [RW-1:0]    q_ra,
  output logic [RW-1:0]    q_rb,
  output logic [RW-1:0]    q_rt,
  output logic             q_rt_wr,
  output logic             q_ra_upd
);

  slot_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SLOT_EMPTY;
    end else if (flush) begin
      state_q <= SLOT_EMPTY;
    end else if (load) begin
      state_q <= SLOT_FULL;
    end else if (unload) begin
      state_q <= SLOT_EMPTY;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_tag    <= '0;
      q_ra     <= '0;
      q_rb     <= '0;
      q_rt     <= '0;
      q_rt_wr  <= 1'b0;
      q_ra_upd <= 1'b0;
    end else if (load && !flush) begin
      q_tag    <= d_tag;
      q_ra     <= d_ra;
      q_rb     <= d_rb;
      q_rt     <= d_rt;
      q_rt_wr  <= d_rt_wr;
      q_ra_upd <= d_ra_upd;
    end
  end

  assign occ = (state_q == SLOT_FULL);

endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
  import issue_pkg::*;
#(
  parameter int NREG = 32,
  parameter int RW   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            mark,
  input  logic [RW-1:0]   mark_rt,
  input  logic            mark_rt_en,
  input  logic [RW-1:0]   mark_ra,
  input  logic            mark_ra_en,
  input  logic            cmp_valid,
  input  logic [RW-1:0]   cmp_reg,
  input  logic [RW-1:0]   q_ra,
  input  logic [RW-1:0]   q_rb,
  input  logic [RW-1:0]   q_rt,
  input  logic            q_rt_wr,
  output logic [NREG-1:0] pend,
  output logic [NREG-1:0] drain,
  output logic            hazard
);

  logic [NREG-1:0] set_v;
  logic [NREG-1:0] clr_v;
  logic [NREG-1:0] hit_v;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign set_v[g] = mark && (reg_match(int'(mark_rt), mark_rt_en, g) ||
                               reg_match(int'(mark_ra), mark_ra_en, g));
    assign clr_v[g] = reg_match(int'(cmp_reg), cmp_valid, g);
    assign hit_v[g] = (pend[g] || drain[g]) &&
                      instr_touches(int'(q_ra), int'(q_rb), int'(q_rt), q_rt_wr, g);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      pend  <= '0;
      drain <= '0;
    end else begin
      pend  <= (pend & ~clr_v) | set_v;
      drain <= pend & clr_v;
    end
  end

  assign hazard = |hit_v;

endmodule

// File: rtl/issue_stage.sv
module issue_stage
  import issue_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int TAG_W = 8,
  parameter int RW    = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [RW-1:0]    in_ra,
  input  logic [RW-1:0]    in_rb,
  input  logic [RW-1:0]    in_rt,
  input  logic             in_rt_wr,
  input  logic             in_ra_upd,
  output logic             stall,
  output logic             out_valid,
  output logic [TAG_W-1:0] out_tag,
  output logic [RW-1:0]    out_ra,
  output logic [RW-1:0]    out_rb,
  output logic [RW-1:0]    out_rt,
  output logic             out_rt_wr,
  output logic             out_ra_upd,
  input  logic             busy,
  input  logic             flush,
  input  logic             cmp_valid,
  input  logic [RW-1:0]    cmp_reg
);

  // Named internal events, visible to the bound checker.
  logic            occ;
  logic            hazard;
  logic            take_ev;
  logic            in_take;
  logic [NREG-1:0] pend;
  logic [NREG-1:0] drain;

  issue_slot #(.TAG_W(TAG_W), .RW(RW)) u_slot (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .load     (in_take),
    .unload   (take_ev),
    .d_tag    (in_tag),
    .d_ra     (in_ra),
    .d_rb     (in_rb),
    .d_rt     (in_rt),
    .d_rt_wr  (in_rt_wr),
    .d_ra_upd (in_ra_upd),
    .occ      (occ),
    .q_tag    (out_tag),
    .q_ra     (out_ra),
    .q_rb     (out_rb),
    .q_rt     (out_rt),
    .q_rt_wr  (out_rt_wr),
    .q_ra_upd (out_ra_upd)
  );

  issue_scoreboard #(.NREG(NREG), .RW(RW)) u_sb (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .mark       (take_ev),
    .mark_rt    (out_rt),
    .mark_rt_en (out_rt_wr),
    .mark_ra    (out_ra),
    .mark_ra_en (out_ra_upd),
    .cmp_valid  (cmp_valid),
    .cmp_reg    (cmp_reg),
    .q_ra       (out_ra),
    .q_rb       (out_rb),
    .q_rt       (out_rt),
    .q_rt_wr    (out_rt_wr),
    .pend       (pend),
    .drain      (drain),
    .hazard     (hazard)
  );

  assign out_valid = occ && !hazard && !flush;
  assign take_ev   = out_valid && !busy;
  assign stall     = occ && !take_ev;
  assign in_take   = in_valid && !stall && !flush;

endmodule

// File: rtl/issue_stage_chk.sv
module issue_stage_chk #(
  parameter int NREG  = 32,
  parameter int TAG_W = 8,
  parameter int RW    = $clog2(NREG)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [TAG_W-1:0] in_tag,
  input logic             stall,
  input logic             out_valid,
  input logic [TAG_W-1:0] out_tag,
  input logic [RW-1:0]    out_ra,
  input logic [RW-1:0]    out_rb,
  input logic [RW-1:0]    out_rt,
  input logic             out_rt_wr,
  input logic             out_ra_upd,
  input logic             busy,
  input logic             flush,
  input logic             cmp_valid,
  input logic [RW-1:0]    cmp_reg,
  input logic             occ,
  input logic             take_ev,
  input logic [NREG-1:0]  pend,
  input logic [NREG-1:0]  drain
);

  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && busy && !flush) |=>
      ((out_valid || flush) && $stable(out_tag) && $stable(out_ra) &&
       $stable(out_rb) && $stable(out_rt) && $stable(out_rt_wr) && $stable(out_ra_upd)));

  assert_refill_R2: assert property (@(posedge clk) disable iff (rst)
    (take_ev && in_valid && !flush) |=> (occ && out_tag == $past(in_tag)));

  assert_stall_full_R3: assert property (@(posedge clk) disable iff (rst)
    (occ && busy) |-> stall);

  assert_stall_empty_R3: assert property (@(posedge clk) disable iff (rst)
    !occ |-> !stall);

  assert_no_raw_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(pend[out_ra] || drain[out_ra] || pend[out_rb] || drain[out_rb]));

  assert_upd_mark_R5: assert property (@(posedge clk) disable iff (rst)
    (take_ev && out_ra_upd && !flush) |=> pend[$past(out_ra)]);

  assert_dst_mark_R6: assert property (@(posedge clk) disable iff (rst)
    (take_ev && out_rt_wr && !flush) |=> pend[$past(out_rt)]);

  assert_drain_R7: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && pend[cmp_reg] && !flush) |=>
      (drain[$past(cmp_reg)] && !pend[$past(cmp_reg)]));

  assert_flush_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!occ && pend == '0 && drain == '0));

  assert_reset_R9: assert property (@(posedge clk)
    rst |=> (!occ && pend == '0 && drain == '0));

endmodule

bind issue_stage issue_stage_chk #(.NREG(NREG), .TAG_W(TAG_W), .RW(RW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_tag     (in_tag),
  .stall      (stall),
  .out_valid  (out_valid),
  .out_tag    (out_tag),
  .out_ra     (out_ra),
  .out_rb     (out_rb),
  .out_rt     (out_rt),
  .out_rt_wr  (out_rt_wr),
  .out_ra_upd (out_ra_upd),
  .busy       (busy),
  .flush      (flush),
  .cmp_valid  (cmp_valid),
  .cmp_reg    (cmp_reg),
  .occ        (occ),
  .take_ev    (take_ev),
  .pend       (pend),
  .drain      (drain)
);

// File: tb/tb_issue_stage.sv
`timescale 1ns/1ps
module tb_issue_stage;

  localparam int NR    = 4;
  localparam int TAG_W = 8;
  localparam int RW    = 2;
  localparam int NPROG = 200;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [TAG_W-1:0] in_tag = '0;
  logic [RW-1:0]    in_ra = '0, in_rb = '0, in_rt = '0;
  logic             in_rt_wr = 1'b0, in_ra_upd = 1'b0;
  logic             stall, out_valid;
  logic [TAG_W-1:0] out_tag;
  logic [RW-1:0]    out_ra, out_rb, out_rt;
  logic             out_rt_wr, out_ra_upd;
  logic             busy = 1'b0, flush = 1'b0, cmp_valid = 1'b0;
  logic [RW-1:0]    cmp_reg = '0;

  int checks = 0;
  int errors = 0;
  int wd = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  issue_stage #(.NREG(NR), .TAG_W(TAG_W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_tag(in_tag),
    .in_ra(in_ra), .in_rb(in_rb), .in_rt(in_rt), .in_rt_wr(in_rt_wr),
    .in_ra_upd(in_ra_upd), .stall(stall), .out_valid(out_valid),
    .out_tag(out_tag), .out_ra(out_ra), .out_rb(out_rb), .out_rt(out_rt),
    .out_rt_wr(out_rt_wr), .out_ra_upd(out_ra_upd), .busy(busy),
    .flush(flush), .cmp_valid(cmp_valid), .cmp_reg(cmp_reg)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive one cycle of inputs at the falling edge, then let outputs settle.
  task automatic drive(input int iv, input int tag, input int ra, input int rb,
                       input int rt, input int wr, input int upd, input int bz,
                       input int cv, input int cr, input int fl);
    @(negedge clk);
    in_valid  = iv[0];
    in_tag    = TAG_W'(tag);
    in_ra     = RW'(ra);
    in_rb     = RW'(rb);
    in_rt     = RW'(rt);
    in_rt_wr  = wr[0];
    in_ra_upd = upd[0];
    busy      = bz[0];
    cmp_valid = cv[0];
    cmp_reg   = RW'(cr);
    flush     = fl[0];
    #1;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0; busy = 1'b0; cmp_valid = 1'b0; flush = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);
    chk(stall == 1'b0, "R9", "stall after reset", int'(stall), 0);
  endtask

  task automatic expect_offer(input string req, input int tag);
    chk(out_valid == 1'b1, req, "out_valid", int'(out_valid), 1);
    chk(int'(out_tag) == tag, req, "out_tag", int'(out_tag), tag);
  endtask

  task automatic expect_idle(input string req);
    chk(out_valid == 1'b0, req, "out_valid held low", int'(out_valid), 0);
  endtask

  // Random pass: busy density sweep with a bench model of pending registers.
  task automatic run_pass(input int busy_pct);
    int pra[NPROG], prb[NPROG], prt[NPROG], pwr[NPROG], pup[NPROG];
    logic [NR-1:0] mp, md, setv, clrv, blk;
    int next_in, next_acc, cyc, cr;
    bit cv, bz, iv, ok;
    for (int i = 0; i < NPROG; i++) begin
      pra[i] = int'($urandom % NR);
      prb[i] = int'($urandom % NR);
      prt[i] = int'($urandom % NR);
      pwr[i] = int'($urandom % 2);
      pup[i] = ((pwr[i] == 0 || pra[i] != prt[i]) && ($urandom % 4 == 0)) ? 1 : 0;
    end
    mp = '0; md = '0; next_in = 0; next_acc = 0; cyc = 0;
    while (next_acc < NPROG && cyc < 6000) begin
      cyc++;
      bz = (int'($urandom % 100) < busy_pct);
      iv = (next_in < NPROG) && ($urandom % 4 != 0);
      cv = 1'b0; cr = 0;
      if (mp != '0 && $urandom % 3 == 0) begin
        int start = int'($urandom % NR);
        for (int k = 0; k < NR; k++) begin
          int idx = (start + k) % NR;
          if (!cv && mp[idx]) begin cv = 1'b1; cr = idx; end
        end
      end
      if (next_in < NPROG)
        drive(int'(iv), next_in, pra[next_in], prb[next_in], prt[next_in],
              pwr[next_in], pup[next_in], int'(bz), int'(cv), cr, 0);
      else
        drive(0, 0, 0, 0, 0, 0, 0, int'(bz), int'(cv), cr, 0);
      setv = '0;
      if (out_valid && !busy) begin
        // R10: in-order, exactly-once acceptance.
        chk(int'(out_tag) == next_acc, "R10", "accepted tag order", int'(out_tag), next_acc);
        blk = mp | md;
        ok = !blk[out_ra] && !blk[out_rb] && !(out_rt_wr && blk[out_rt]);
        // R4: never accepted while a register it uses is pending.
        chk(ok, "R4", "accepted with blocked register", int'(blk), 0);
        if (out_rt_wr) setv[out_rt] = 1'b1;
        if (out_ra_upd) setv[out_ra] = 1'b1;
        next_acc++;
      end
      if (iv && !stall && next_in < NPROG) next_in++;
      clrv = '0;
      if (cv) clrv[cr] = 1'b1;
      md = clrv & mp;
      mp = (mp & ~clrv) | setv;
    end
    chk(next_acc == NPROG, "R10", "instructions accepted in pass", next_acc, NPROG);
  endtask

  initial begin
    do_reset();

    // R2/R3: empty slot captures; offer appears next cycle.
    drive(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk(stall == 1'b0, "R3", "stall with empty slot", int'(stall), 0);
    // R1: busy holds the offer; R3: stall while full and not taken.
    drive(1, 2, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    expect_offer("R1", 1);
    chk(stall == 1'b1, "R3", "stall while busy", int'(stall), 1);
    drive(1, 2, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    expect_offer("R1", 1);
    drive(1, 2, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    expect_offer("R1", 1);
    drive(1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    expect_offer("R1", 1);
    chk(stall == 1'b0, "R3", "stall when offer taken", int'(stall), 0);
    idle();
    expect_offer("R2", 2);
    idle();
    expect_idle("R2");

    // R4 and R7: read after write, completion and extra drain cycle.
    drive(1, 3, 0, 0, 1, 1, 0, 0, 0, 0, 0);
    drive(1, 4, 1, 0, 2, 0, 0, 0, 0, 0, 0);
    expect_offer("R4", 3);
    idle();
    expect_idle("R4");
    chk(stall == 1'b1, "R3", "stall while blocked", int'(stall), 1);
    idle();
    expect_idle("R4");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0);
    expect_idle("R7");
    idle();
    expect_idle("R7");
    idle();
    expect_offer("R7", 4);
    idle();
    expect_idle("R7");

    // R5: base-register update blocks a reader of that register.
    drive(1, 5, 2, 0, 0, 0, 1, 0, 0, 0, 0);
    drive(1, 6, 0, 2, 0, 0, 0, 0, 0, 0, 0);
    expect_offer("R5", 5);
    idle();
    expect_idle("R5");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 0);
    expect_idle("R5");
    idle();
    expect_idle("R7");
    idle();
    expect_offer("R5", 6);

    // R6: write after write on register 3.
    drive(1, 7, 0, 0, 3, 1, 0, 0, 0, 0, 0);
    drive(1, 8, 1, 1, 3, 1, 0, 0, 0, 0, 0);
    expect_offer("R6", 7);
    idle();
    expect_idle("R6");
    chk(stall == 1'b1, "R3", "stall while WAW blocked", int'(stall), 1);

    // R8: flush drops blocked slot, refuses input, clears scoreboard.
    drive(1, 9, 3, 0, 0, 0, 0, 0, 0, 0, 1);
    expect_idle("R8");
    drive(1, 9, 3, 0, 0, 0, 0, 0, 0, 0, 0);
    expect_idle("R8");
    chk(stall == 1'b0, "R8", "slot empty after flush", int'(stall), 0);
    idle();
    expect_offer("R8", 9);
    idle();
    expect_idle("R8");

    // Busy-density sweep with random dependent streams (R4, R10).
    for (int p = 0; p < 4; p++) begin
      do_reset();
      run_pass(p * 30);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", wd);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule